// File: doc/BRIEF.md
# Float-to-Fixed Converter

This block turns a binary floating-point word (sign, biased exponent and stored fraction, in that order from the most significant bit down) into a signed two's-complement fixed-point word. Parameters set the float field widths and the fixed word width. The number of fractional bits in the result is either a constant fixed at elaboration or a value taken each cycle from an input port.

The significand, with its hidden one restored, is moved by a barrel shifter. The distance and direction of the move come from the unbiased exponent and the radix point. The magnitude is truncated, the sign is applied, and a range stage flags any value that the fixed word cannot hold. A flagged value is saturated. Zero and subnormal inputs give zero. Infinity and NaN give a flagged, saturated result.

The datapath is combinational. An optional output stage registers the result; a valid input enables it and a valid output follows one cycle later.

Top module: `f2x_convert`

## Requirements
- R1: The input word is read as sign at the top bit, then EXP_W exponent bits, then MAN_W fraction bits at the bottom. A normal input has the value (1 + m/2^MAN_W) * 2^(e - (2^(EXP_W-1) - 1)).
- R2: For a positive normal input that is in range, the output equals floor(value * 2^rp), where rp is the radix point. Fraction bits below the radix point are discarded, and values smaller than one least significant step give 0.
- R3: An input whose exponent field is all zeros (plus or minus zero, or a subnormal) gives output 0 with the overflow flag low.
- R4: An input whose exponent field is all ones (infinity or NaN) raises the overflow flag. The output is 2^(FIX_W-1)-1 when the sign bit is 0 and -2^(FIX_W-1) when the sign bit is 1.
- R5: A negative normal input that is in range gives the two's complement of the truncated magnitude, so it rounds toward zero.
- R6: A normal input whose truncated magnitude is at least 2^(FIX_W-1) (positive) or greater than 2^(FIX_W-1) (negative) raises the overflow flag and saturates as in R4. The value -2^(FIX_W-1) itself is produced without overflow.
- R7: With RP_RUNTIME=1, the unsigned RP_W-bit input radix_in gives the fractional bit count. It is taken together with each sample, so it can change from one sample to the next.
- R8: With OUT_REG=1, a sample presented with in_vld high appears on fix_out/ovf_out one cycle later, and out_vld is in_vld delayed by one cycle.
- R9: In a cycle where in_vld is low, fix_out and ovf_out keep their values.
- R10: While rst_n is low, out_vld, fix_out and ovf_out are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| in_vld | input | 1 | Sample valid; enables the output register |
| flt_in | input | FLT_W | Floating-point input word |
| radix_in | input | RP_W | Runtime radix point (fraction bit count) |
| out_vld | output | 1 | Result valid |
| fix_out | output | FIX_W | Signed fixed-point result |
| ovf_out | output | 1 | Overflow / unrepresentable flag |

## Verification
Directed inputs cover the following cases:
- Exact powers of two and mixed fractions, at several radix points. These separate a correct shift distance from one that is off by one, and a left shift from a right shift.
- Zero, negative zero and subnormals, which separate the zero class from the normal path.
- Infinities and NaN of both signs, which exercise the saturation polarity.
- Magnitudes just around 2^(FIX_W-1), which separate the asymmetric positive and negative limits.

Random samples then spread exponents across and beyond the representable window, with a new radix point each cycle, and idle cycles between them exercise the hold behaviour.

// File: rtl/f2x_pkg.sv
package f2x_pkg;

  // Classification of an incoming float word.
  typedef enum logic [1:0] {
    CLS_ZERO = 2'd0,  // exponent field all zeros: zero or subnormal
    CLS_NORM = 2'd1,  // ordinary normal number
    CLS_SPEC = 2'd2   // exponent field all ones: infinity or NaN
  } f2x_cls_e;

endpackage

// File: rtl/f2x_unpack.sv
module f2x_unpack
  import f2x_pkg::*;
#(
  parameter int FLT_W = 32,
  parameter int EXP_W = 8,
  parameter int MAN_W = 23
) (
  input  logic [FLT_W-1:0] flt,
  output logic             sign,
  output logic [EXP_W-1:0] expo,
  output logic [MAN_W:0]   sig,
  output f2x_cls_e         cls
);

  localparam logic [EXP_W-1:0] EXP_ONES = '1;

  always_comb begin
    sign = flt[FLT_W-1];
    expo = flt[FLT_W-2 -: EXP_W];
    // restore hidden one
    sig  = {1'b1, flt[MAN_W-1:0]};
    if (expo == '0) begin
      cls = CLS_ZERO;
    end else if (expo == EXP_ONES) begin
      cls = CLS_SPEC;
    end else begin
      cls = CLS_NORM;
    end
  end

endmodule

// File: rtl/f2x_shift_calc.sv
module f2x_shift_calc #(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23,
  parameter int RP_W  = 6,
  parameter int AMT_W = 6,
  parameter int LMAX  = 32,
  parameter int RMAX  = 24
) (
  input  logic [EXP_W-1:0] expo,
  input  logic [RP_W-1:0]  rp,
  output logic             dir_right,
  output logic [AMT_W-1:0] amt
);

  localparam int SC_W = EXP_W + RP_W + $clog2(MAN_W + 2) + 2;
  localparam int BIAS = (1 << (EXP_W - 1)) - 1;
  localparam logic [SC_W-1:0] OFFS   = SC_W'(BIAS + MAN_W);
  localparam logic [SC_W-1:0] LCLAMP = SC_W'(LMAX);
  localparam logic [SC_W-1:0] RCLAMP = SC_W'(RMAX);

  logic [SC_W-1:0] sh;
  logic [SC_W-1:0] sh_neg;

  always_comb begin
    // signed distance: unbiased exponent + radix - fraction width
    sh        = {{(SC_W-EXP_W){1'b0}}, expo} + {{(SC_W-RP_W){1'b0}}, rp} - OFFS;
    sh_neg    = -sh;
    dir_right = sh[SC_W-1];
    if (dir_right) begin
      amt = (sh_neg > RCLAMP) ? AMT_W'(RMAX) : sh_neg[AMT_W-1:0];
    end else begin
      amt = (sh > LCLAMP) ? AMT_W'(LMAX) : sh[AMT_W-1:0];
    end
  end

endmodule

// File: rtl/f2x_shifter.sv
module f2x_shifter #(
  parameter int SIG_W  = 24,
  parameter int WIDE_W = 56,
  parameter int AMT_W  = 6
) (
  input  logic [SIG_W-1:0]  sig,
  input  logic              dir_right,
  input  logic [AMT_W-1:0]  amt,
  output logic [WIDE_W-1:0] mag
);

  logic [WIDE_W-1:0] stg [0:AMT_W];

  assign stg[0] = {{(WIDE_W-SIG_W){1'b0}}, sig};

  // one mux level per amount bit
  for (genvar i = 0; i < AMT_W; i++) begin : g_stage
    always_comb begin
      if (!amt[i]) begin
        stg[i+1] = stg[i];
      end else if (dir_right) begin
        stg[i+1] = stg[i] >> (1 << i);
      end else begin
        stg[i+1] = stg[i] << (1 << i);
      end
    end
  end

  assign mag = stg[AMT_W];

endmodule

// File: rtl/f2x_range.sv
module f2x_range
  import f2x_pkg::*;
#(
  parameter int WIDE_W = 56,
  parameter int FIX_W  = 32
) (
  input  logic [WIDE_W-1:0] mag,
  input  logic              sign,
  input  f2x_cls_e          cls,
  output logic [FIX_W-1:0]  fix,
  output logic              ovf
);

  localparam logic [WIDE_W-1:0] LIM     = WIDE_W'(1) << (FIX_W - 1);
  localparam logic [FIX_W-1:0]  POS_SAT = {1'b0, {(FIX_W-1){1'b1}}};
  localparam logic [FIX_W-1:0]  NEG_SAT = {1'b1, {(FIX_W-1){1'b0}}};

  logic             over;
  logic [FIX_W-1:0] low;

  always_comb begin
    // negative side reaches one step further than positive
    over = sign ? (mag > LIM) : (mag >= LIM);
    low  = mag[FIX_W-1:0];
    unique case (cls)
      CLS_ZERO: begin
        ovf = 1'b0;
        fix = '0;
      end
      CLS_SPEC: begin
        ovf = 1'b1;
        fix = sign ? NEG_SAT : POS_SAT;
      end
      default: begin
        ovf = over;
        if (over) begin
          fix = sign ? NEG_SAT : POS_SAT;
        end else begin
          fix = sign ? (~low + FIX_W'(1)) : low;
        end
      end
    endcase
  end

endmodule

// File: rtl/f2x_convert.sv
module f2x_convert
  import f2x_pkg::*;
#(
  parameter int FLT_W      = 32,
  parameter int EXP_W      = 8,
  parameter int MAN_W      = 23,
  parameter int FIX_W      = 32,
  parameter int RP_W       = 6,
  parameter int RP_RUNTIME = 1,
  parameter int RP_CONST   = 16,
  parameter int OUT_REG    = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_vld,
  input  logic [FLT_W-1:0] flt_in,
  input  logic [RP_W-1:0]  radix_in,
  output logic             out_vld,
  output logic [FIX_W-1:0] fix_out,
  output logic             ovf_out
);

  localparam int SIG_W  = MAN_W + 1;
  localparam int WIDE_W = SIG_W + FIX_W;
  localparam int AMT_W  = $clog2(WIDE_W + 1);

  logic             sign;
  logic [EXP_W-1:0] expo;
  logic [SIG_W-1:0] sig;
  f2x_cls_e         cls;
  logic [RP_W-1:0]  rp;
  logic             dir_right;
  logic [AMT_W-1:0] amt;
  logic [WIDE_W-1:0] mag;
  logic [FIX_W-1:0] fix_c;
  logic             ovf_c;

  // radix point source picked at elaboration
  if (RP_RUNTIME != 0) begin : g_rp_port
    assign rp = radix_in;
  end else begin : g_rp_const
    logic unused_radix;
    assign unused_radix = ^radix_in;
    assign rp = RP_W'(RP_CONST);
  end

  f2x_unpack #(.FLT_W(FLT_W), .EXP_W(EXP_W), .MAN_W(MAN_W)) u_unpack (
    .flt (flt_in),
    .sign(sign),
    .expo(expo),
    .sig (sig),
    .cls (cls)
  );

  f2x_shift_calc #(
    .EXP_W(EXP_W), .MAN_W(MAN_W), .RP_W(RP_W),
    .AMT_W(AMT_W), .LMAX(FIX_W), .RMAX(SIG_W)
  ) u_shcalc (
    .expo     (expo),
    .rp       (rp),
    .dir_right(dir_right),
    .amt      (amt)
  );

  f2x_shifter #(.SIG_W(SIG_W), .WIDE_W(WIDE_W), .AMT_W(AMT_W)) u_shift (
    .sig      (sig),
    .dir_right(dir_right),
    .amt      (amt),
    .mag      (mag)
  );

  f2x_range #(.WIDE_W(WIDE_W), .FIX_W(FIX_W)) u_range (
    .mag (mag),
    .sign(sign),
    .cls (cls),
    .fix (fix_c),
    .ovf (ovf_c)
  );

  if (OUT_REG != 0) begin : g_oreg
    logic             vld_q, vld_d;
    logic [FIX_W-1:0] fix_q, fix_d;
    logic             ovf_q, ovf_d;

    always_comb begin
      vld_d = in_vld;
      fix_d = fix_q;
      ovf_d = ovf_q;
      if (in_vld) begin
        fix_d = fix_c;
        ovf_d = ovf_c;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vld_q <= 1'b0;
        fix_q <= '0;
        ovf_q <= 1'b0;
      end else begin
        vld_q <= vld_d;
        fix_q <= fix_d;
        ovf_q <= ovf_d;
      end
    end

    assign out_vld = vld_q;
    assign fix_out = fix_q;
    assign ovf_out = ovf_q;
  end else begin : g_ocomb
    logic unused_clk;
    assign unused_clk = clk ^ rst_n;
    assign out_vld    = in_vld;
    assign fix_out    = fix_c;
    assign ovf_out    = ovf_c;
  end

endmodule

// File: rtl/f2x_convert_chk.sv
module f2x_convert_chk #(
  parameter int FLT_W   = 32,
  parameter int EXP_W   = 8,
  parameter int FIX_W   = 32,
  parameter int RP_W    = 6,
  parameter int OUT_REG = 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_vld,
  input logic [FLT_W-1:0] flt_in,
  input logic [RP_W-1:0]  radix_in,
  input logic             out_vld,
  input logic [FIX_W-1:0] fix_out,
  input logic             ovf_out
);

  localparam logic [FIX_W-1:0] POS_SAT = {1'b0, {(FIX_W-1){1'b1}}};
  localparam logic [FIX_W-1:0] NEG_SAT = {1'b1, {(FIX_W-1){1'b0}}};
  localparam logic [EXP_W-1:0] EXP_ONES = '1;

  logic [EXP_W-1:0] e_fld;
  logic             unused_rp;
  assign e_fld     = flt_in[FLT_W-2 -: EXP_W];
  assign unused_rp = ^radix_in;

  if (OUT_REG != 0) begin : g_chk
    a_r8_vld_rise: assert property (@(posedge clk) disable iff (!rst_n)
      in_vld |=> out_vld);
    a_r8_vld_fall: assert property (@(posedge clk) disable iff (!rst_n)
      !in_vld |=> !out_vld);
    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !in_vld |=> ($stable(fix_out) && $stable(ovf_out)));
    a_r3_zero_class: assert property (@(posedge clk) disable iff (!rst_n)
      (in_vld && e_fld == '0) |=> (fix_out == '0 && !ovf_out));
    a_r4_special_pos: assert property (@(posedge clk) disable iff (!rst_n)
      (in_vld && e_fld == EXP_ONES && !flt_in[FLT_W-1]) |=> (ovf_out && fix_out == POS_SAT));
    a_r4_special_neg: assert property (@(posedge clk) disable iff (!rst_n)
      (in_vld && e_fld == EXP_ONES && flt_in[FLT_W-1]) |=> (ovf_out && fix_out == NEG_SAT));
  end

  // R6: a flagged result is always one of the two saturation values
  a_r6_ovf_saturates: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_out |-> (fix_out == POS_SAT || fix_out == NEG_SAT));

endmodule

bind f2x_convert f2x_convert_chk #(
  .FLT_W(FLT_W), .EXP_W(EXP_W), .FIX_W(FIX_W), .RP_W(RP_W), .OUT_REG(OUT_REG)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .in_vld  (in_vld),
  .flt_in  (flt_in),
  .radix_in(radix_in),
  .out_vld (out_vld),
  .fix_out (fix_out),
  .ovf_out (ovf_out)
);

// File: tb/f2x_convert_test.sv
module f2x_convert_test;

  localparam int FLT_W = 32;
  localparam int FIX_W = 32;
  localparam int RP_W  = 6;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             in_vld = 1'b0;
  logic [FLT_W-1:0] flt_in = '0;
  logic [RP_W-1:0]  radix_in = '0;
  logic             out_vld;
  logic [FIX_W-1:0] fix_out;
  logic             ovf_out;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  f2x_convert uut (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .flt_in(flt_in),
    .radix_in(radix_in), .out_vld(out_vld), .fix_out(fix_out), .ovf_out(ovf_out)
  );

  // Behavioural reference: exact arithmetic on a wide integer.
  function automatic void ref_conv(input logic [31:0] f, input logic [5:0] rp,
                                   output logic [31:0] fx, output bit ov,
                                   output string tag);
    bit s;
    int e, sh;
    logic [127:0] mg, lim;
    s = f[31];
    e = int'(f[30:23]);
    if (e == 0) begin
      fx = '0; ov = 1'b0; tag = "R3";
    end else if (e == 255) begin
      ov = 1'b1; fx = s ? 32'h8000_0000 : 32'h7fff_ffff; tag = "R4";
    end else begin
      sh = e - 127 + int'(rp) - 23;
      mg = {104'd0, 1'b1, f[22:0]};
      if (sh > 100)      mg = 128'd1 << 100;
      else if (sh >= 0)  mg = mg << sh;
      else               mg = mg >> (-sh);
      lim = 128'd1 << 31;
      ov  = s ? (mg > lim) : (mg >= lim);
      if (ov)     fx = s ? 32'h8000_0000 : 32'h7fff_ffff;
      else if (s) fx = -mg[31:0];
      else        fx = mg[31:0];
      tag = ov ? "R6/R1/R7" : (s ? "R5/R1/R7" : "R2/R1/R7");
    end
  endfunction

  // Cycle model of the output stage (R8, R9, R10)
  logic        m_vld;
  logic [31:0] m_fix;
  bit          m_ovf;
  string       m_tag;

  always @(posedge clk or negedge rst_n) begin
    logic [31:0] fx;
    bit ov;
    string tg;
    if (!rst_n) begin
      m_vld <= 1'b0; m_fix <= '0; m_ovf <= 1'b0; m_tag <= "R10";
    end else begin
      m_vld <= in_vld;
      if (in_vld) begin
        ref_conv(flt_in, radix_in, fx, ov, tg);
        m_fix <= fx; m_ovf <= ov; m_tag <= tg;
      end else begin
        m_tag <= "R9";
      end
    end
  end

  task automatic compare();
    checks++;
    if (out_vld !== m_vld) begin
      errors++;
      $display("FAIL R8 out_vld actual %b expected %b", out_vld, m_vld);
    end
    checks++;
    if (fix_out !== m_fix || ovf_out !== m_ovf) begin
      errors++;
      $display("FAIL %s fix/ovf actual %h/%b expected %h/%b",
               m_tag, fix_out, ovf_out, m_fix, m_ovf);
    end
  endtask

  task automatic put(input logic [31:0] f, input logic [5:0] rp, input bit v);
    @(negedge clk);
    compare();
    flt_in = f; radix_in = rp; in_vld = v;
  endtask

  initial begin
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      compare();              // R10 reset state
    end
    rst_n = 1'b1;
    // R2: 1.0 at rp 16, 0.5 at rp 0 truncates, 1.5 at rp 1
    put(32'h3F80_0000, 6'd16, 1'b1);
    put(32'h3F00_0000, 6'd0, 1'b1);
    put(32'h3FC0_0000, 6'd1, 1'b1);
    put(32'h4049_0FDB, 6'd20, 1'b1);  // pi
    // R5: -1.0, -2.75 at rp 2, -0.75 at rp 0 -> 0
    put(32'hBF80_0000, 6'd16, 1'b1);
    put(32'hC030_0000, 6'd2, 1'b1);
    put(32'hBF40_0000, 6'd0, 1'b1);
    // R3: +0, -0, subnormal
    put(32'h0000_0000, 6'd10, 1'b1);
    put(32'h8000_0000, 6'd10, 1'b1);
    put(32'h0000_0001, 6'd63, 1'b1);
    // R4: +inf, -inf, NaN both signs
    put(32'h7F80_0000, 6'd5, 1'b1);
    put(32'hFF80_0000, 6'd5, 1'b1);
    put(32'h7FC0_0001, 6'd5, 1'b1);
    put(32'hFFC0_0000, 6'd5, 1'b1);
    // R6: +2^31 overflows, -2^31 fits, -2^31*1.x overflows, 2^30 at rp 1
    put(32'h4F00_0000, 6'd0, 1'b1);
    put(32'hCF00_0000, 6'd0, 1'b1);
    put(32'hCF00_0001, 6'd0, 1'b1);
    put(32'h4E80_0000, 6'd1, 1'b1);
    put(32'h4EFF_FFFF, 6'd0, 1'b1);
    put(32'h7F7F_FFFF, 6'd63, 1'b1);
    // R2 tiny value to zero, R9 idle cycles hold
    put(32'h0D80_0000, 6'd63, 1'b1);
    put(32'h4000_0000, 6'd3, 1'b0);
    put(32'h4000_0000, 6'd3, 1'b0);
    // R7 random stream with varying radix
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] f;
      f = $urandom;
      if (($urandom % 4) != 0) f[30:23] = 8'(100 + ($urandom % 70));
      put(f, 6'($urandom % 64), ($urandom % 5) != 0);
    end
    put('0, '0, 1'b0);
    put('0, '0, 1'b0);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule